// File: doc/BRIEF.md
# Serial 1101 Pattern Detector (JK Flip-Flop Mealy Form)

This block watches a one-bit serial stream, one bit per rising clock edge, and raises its detect output during the cycle in which the bit on the input completes the pattern 1, 1, 0, 1. The output is a Mealy output: it is formed from the present state and the current input bit, so it rises in the same cycle as the closing 1, not one cycle later. Matches may overlap, so the trailing 1 of one match can serve as the first 1 of the next.

The state lives in two JK flip-flops. Fixed gate equations drive their J and K pins and the output. There is no case statement. A synchronous active-high reset clears both flip-flops and holds the output low.

Top module: `pat1101_jk`

## Requirements
- R1: When `rst` is high at a rising edge, both state bits become 0 (the idle state). After reset, a detection needs all four pattern bits to arrive after reset is released.
- R2: `hit` is 0 in every cycle in which `rst` is high, whatever the state and `din`.
- R3: `hit` is 1 in the same cycle as the `din` bit that completes 1,1,0,1, and 0 in all other cycles.
- R4: Matches overlap. The stream 1101101 gives `hit` on its 4th and 7th bits only.
- R5: The state code is {q1,q0}: idle=00, one 1 seen=01, 11 seen=11, 110 seen=10. After a detection the next state is 01.
- R6: In state 10, an input of 0 returns the machine to idle. The stream 11001101 gives `hit` only on its 8th bit.
- R7: In state 11, an input of 1 keeps the state at 11. The stream 11101 gives `hit` only on its 5th bit.
- R8: Each state flip-flop holds on J=0,K=0, clears on J=0,K=1, sets on J=1,K=0 and toggles on J=1,K=1 at the rising edge. The equations are J1=din·q0, K1=¬q0, J0=din, K0=¬din.
- R9: Over long random streams, `hit` equals 1 exactly when the last three accepted bits and the current `din` read 1101. Bits accepted before the latest reset do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial input bit, one per cycle |
| hit | output | 1 | Mealy detect flag, combinational from `din` |

## Verification
Assertions check on every cycle the flip-flop rules: set, clear, hold, toggle and reset clear. They also check the state moves out of the 11 and 110 states and after a detection, and that the output stays low under reset. The bench scenarios are the only way to show the pattern results as a whole: which bits of an overlapping stream fire, that no false match appears after reset, and that the output agrees with a four-bit window model over long random streams.

// File: rtl/pat1101_pkg.sv
package pat1101_pkg;
  localparam int STATE_W = 2;
  localparam logic [STATE_W-1:0] ST_IDLE  = 2'b00;
  localparam logic [STATE_W-1:0] ST_ONE   = 2'b01;
  localparam logic [STATE_W-1:0] ST_TWO   = 2'b11;
  localparam logic [STATE_W-1:0] ST_THREE = 2'b10;
endpackage

// File: rtl/pat1101_jk_cell.sv
module pat1101_jk_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else begin
      case ({j, k})
        2'b01:   q <= 1'b0;
        2'b10:   q <= 1'b1;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end

  // R1
  jk_rst_chk: assert property (@(posedge clk) rst |=> (q == RST_VAL));
  // R8
  jk_set_chk: assert property (@(posedge clk) disable iff (rst) (j && !k) |=> q);
  // R8
  jk_clr_chk: assert property (@(posedge clk) disable iff (rst) (!j && k) |=> !q);
  // R8
  jk_hold_chk: assert property (@(posedge clk) disable iff (rst) (!j && !k) |=> (q == $past(q)));
  // R8
  jk_tgl_chk: assert property (@(posedge clk) disable iff (rst) (j && k) |=> (q != $past(q)));
endmodule

// File: rtl/pat1101_excite.sv
module pat1101_excite
  import pat1101_pkg::*;
(
  input  logic               din,
  input  logic [STATE_W-1:0] q,
  output logic [STATE_W-1:0] j,
  output logic [STATE_W-1:0] k,
  output logic               match
);
  always_comb begin
    j[1]  = din & q[0];
    k[1]  = ~q[0];
    j[0]  = din;
    k[0]  = ~din;
    match = din & q[1] & ~q[0];
  end
endmodule

// File: rtl/pat1101_jk.sv
module pat1101_jk
  import pat1101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  logic [STATE_W-1:0] st, jv, kv;
  logic               raw_hit;

  for (genvar g = 0; g < STATE_W; g++) begin : g_ff
    pat1101_jk_cell #(.RST_VAL(1'b0)) u_ff (
      .clk(clk), .rst(rst), .j(jv[g]), .k(kv[g]), .q(st[g])
    );
  end

  pat1101_excite u_exc (
    .din(din), .q(st), .j(jv), .k(kv), .match(raw_hit)
  );

  assign hit = raw_hit & ~rst;

  // R2
  always_comb begin
    if (rst) rst_quiet_chk: assert (!hit);
  end

  // R5
  post_hit_chk: assert property (@(posedge clk) disable iff (rst) hit |=> (st == ST_ONE));
  // R6
  back_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_THREE && !din) |=> (st == ST_IDLE));
  // R7
  stay_two_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TWO && din) |=> (st == ST_TWO));
endmodule

// File: tb/pat1101_jk_test.sv
`timescale 1ns/1ps
module pat1101_jk_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;
  int   n_run = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  pat1101_jk uut (.clk(clk), .rst(rst), .din(din), .hit(hit));

  typedef struct packed {
    logic [5:0]  len;
    logic [31:0] bits;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{6'd7, 32'b1101101,  32'b0001001},
    '{6'd5, 32'b11101,    32'b00001},
    '{6'd8, 32'b11001101, 32'b00000001},
    '{6'd4, 32'b1011,     32'b0000},
    '{6'd8, 32'b11011101, 32'b00010001}
  };

  task automatic check(input logic e, input string tag);
    n_run++;
    if (hit !== e) begin
      n_bad++;
      $display("FAIL %s: hit=%b expected=%b", tag, hit, e);
    end
  endtask

  task automatic step(input logic b, input logic e, input string tag);
    @(negedge clk);
    din = b;
    #1;
    check(e, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] hist;
    logic       b, e;
    // R1, R2: reset state
    @(negedge clk); #1;
    check(1'b0, "R2 reset state output");
    do_reset();

    // R3 R4 R5 R6 R7: vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int i = VECS[v].len - 1; i >= 0; i--)
        step(VECS[v].bits[i], VECS[v].exp[i], $sformatf("R3/R4/R6/R7 vec%0d bit%0d", v, i));
    end

    // R2: reset while in state 10 with din=1
    do_reset();
    step(1'b1, 1'b0, "R3 prefix");
    step(1'b1, 1'b0, "R3 prefix");
    step(1'b0, 1'b0, "R3 prefix");
    @(negedge clk);
    rst = 1'b1;
    din = 1'b1;
    #1;
    check(1'b0, "R2 hit masked by reset");
    @(negedge clk);
    rst = 1'b0;
    din = 1'b0;
    // R1: state cleared, partial pattern must not fire
    step(1'b1, 1'b0, "R1 after reset");
    step(1'b0, 1'b0, "R1 after reset");
    step(1'b1, 1'b0, "R1 no match from pre-reset bits");
    step(1'b1, 1'b0, "R1 after reset");
    step(1'b0, 1'b0, "R1 after reset");
    step(1'b1, 1'b1, "R1 full pattern after reset");
    // R5: after hit the state is 01, so 101 completes another match
    step(1'b1, 1'b0, "R5 state 01 then 1");
    step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, "R5 next match");

    // R8 R9: random streams against a window model
    for (int blk = 0; blk < 4; blk++) begin
      do_reset();
      hist = 3'b000;
      for (int i = 0; i < 2000; i++) begin
        b = 1'($urandom_range(0, 1));
        e = ({hist, b} == 4'b1101);
        step(b, e, "R8/R9 random window compare");
        hist = {hist[1:0], b};
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule